// File: doc/BRIEF.md
# Capture-Compare Timer with Output Events

A free-running 16-bit counter serves as the timebase for four capture channels and three compare channels. Each capture channel watches its own input pin through a two-stage synchroniser. On the edge its mode selects (rising, falling, either, or none), the channel copies the current count into its capture register and raises its capture flag.

Each compare channel flags a match in any running cycle in which the count equals its compare value. Matches drive two groups of outputs. Six set/reset outputs each follow one assigned compare channel and apply a pending set or pending clear bit when that channel matches. Two toggle outputs invert on a match of their own compare channel.

Software uses a write port and a separate combinational read port. Through them it starts and stops the counter, loads the count, programs compares, edge modes, output routing and pending actions, reads the captures, and clears flags by writing 1. One interrupt line reports any flag whose enable bit is set.

Top module: `cc_timer`

## Requirements
- R1: The count rises by one on each clock while the run bit (address 1, bit 0) is 1 and holds while it is 0. A write to address 0 loads the count and takes precedence over the increment.
- R2: A running step from 0xFFFF to 0x0000 sets the overflow flag, which is flag bit 7.
- R3: The edge mode register at address 9 holds two bits per capture channel, with channel c at bits [2c+1:2c]. The codes are 00 off, 01 rising, 10 falling and 11 both. A channel whose mode does not match the edge neither captures nor sets its flag.
- R4: A channel that fires stores the count in its capture register (addresses 5 to 8) and sets flag bit c. If the pin changes while the count reads V, the register holds V+2 when the counter is running.
- R5: While running, a count equal to compare register k (addresses 2 to 4) sets flag bit 4+k on the next clock.
- R6: Toggle output k (k = 0, 1) inverts on the clock after a match of compare k and is otherwise unchanged.
- R7: Set/reset output j is routed by bits [2j+1:2j] of address 10, where a value of 3 means no compare. On a match of its compare, the output goes to 1 if pending-set bit j (address 11) is set. Otherwise it goes to 0 if pending-clear bit 8+j is set. Set wins over clear, and both pending bits are consumed. With no pending bit the output stays unchanged, and unmatched pending bits persist.
- R8: Writing the flag register (address 12) clears each flag written with 1. Bits written with 0 are left alone, and an event in the same cycle wins over the clear.
- R9: `irq` is 1 when any flag is set whose bit is also set in the enable register (address 13).
- R10: After reset the count, every register, every flag and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Combinational read data |
| cap_in | input | 4 | Capture pins, one per channel |
| sr_out | output | 6 | Set/reset outputs |
| tog_out | output | 2 | Toggle outputs |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
A register write takes effect at the edge it is presented on, and a match or overflow shows in flags and outputs one clock after the cycle in which the count holds the matching value. A capture lands three edges after the pin change, holding the count seen at the change plus two. The driver applies stimulus just after a rising edge and queues the expected values only once all the latency edges have passed. The monitor compares them at falling edges, so every check samples settled state.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int AW           = 4;
    localparam int PEND_CLR_LSB = 8;

    localparam logic [AW-1:0] A_TIMER = 4'd0;
    localparam logic [AW-1:0] A_CTRL  = 4'd1;
    localparam logic [AW-1:0] A_CMP0  = 4'd2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/cct_capture.sv
module cct_capture #(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pin,
    input  logic [2*NCH-1:0] mode,
    output logic [NCH-1:0]   fire
);
    import cct_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] s1;
        logic [NCH-1:0] s2;
        logic [NCH-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = pin;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_edge
        edge_mode_e m;
        logic       rise, fall;
        assign m    = edge_mode_e'(mode[2*c +: 2]);
        assign rise = sync_q.s2[c] & ~sync_q.prev[c];
        assign fall = ~sync_q.s2[c] & sync_q.prev[c];
        assign fire[c] = ((m == EDGE_RISE || m == EDGE_BOTH) && rise) ||
                         ((m == EDGE_FALL || m == EDGE_BOTH) && fall);
    end
endmodule

// File: rtl/cct_match.sv
module cct_match #(
    parameter int TW   = 16,
    parameter int NCMP = 3
) (
    input  logic                     run,
    input  logic [TW-1:0]            count,
    input  logic [NCMP-1:0][TW-1:0]  cmp,
    output logic [NCMP-1:0]          match
);
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        assign match[k] = run && (count == cmp[k]);
    end
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
    parameter int TW   = 16,
    parameter int NCAP = 4,
    parameter int NCMP = 3,
    parameter int NSR  = 6,
    parameter int NTG  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [cct_pkg::AW-1:0] wr_addr,
    input  logic [TW-1:0]          wr_data,
    input  logic [cct_pkg::AW-1:0] rd_addr,
    output logic [TW-1:0]          rd_data,
    input  logic [NCAP-1:0]        cap_in,
    output logic [NSR-1:0]         sr_out,
    output logic [NTG-1:0]         tog_out,
    output logic                   irq
);
    import cct_pkg::*;

    localparam int NFLG   = NCAP + NCMP + 1;
    localparam int SELW   = $clog2(NCMP + 1);
    localparam int NSEL   = 2 ** SELW;
    localparam logic [AW-1:0] A_CAP0 = A_CMP0 + AW'(NCMP);
    localparam logic [AW-1:0] A_EDGE = A_CAP0 + AW'(NCAP);
    localparam logic [AW-1:0] A_SEL  = A_EDGE + 4'd1;
    localparam logic [AW-1:0] A_PEND = A_EDGE + 4'd2;
    localparam logic [AW-1:0] A_FLAG = A_EDGE + 4'd3;
    localparam logic [AW-1:0] A_IREN = A_EDGE + 4'd4;

    typedef struct packed {
        logic [TW-1:0]             count;
        logic                      run;
        logic [NCMP-1:0][TW-1:0]   cmp;
        logic [NCAP-1:0][TW-1:0]   cap;
        logic [2*NCAP-1:0]         edge_mode;
        logic [NSR*SELW-1:0]       sel;
        logic [NSR-1:0]            pset;
        logic [NSR-1:0]            pclr;
        logic [NFLG-1:0]           flags;
        logic [NFLG-1:0]           irqen;
        logic [NSR-1:0]            sr;
        logic [NTG-1:0]            tog;
    } state_t;

    state_t state_d, state_q;

    logic [NCAP-1:0] cap_fire;
    logic [NCMP-1:0] match;
    logic [NSEL-1:0] match_ext;
    logic [NFLG-1:0] events;
    logic            ovf_ev;

    cct_capture #(.NCH(NCAP)) i_capture (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_in),
        .mode (state_q.edge_mode),
        .fire (cap_fire)
    );

    cct_match #(.TW(TW), .NCMP(NCMP)) i_match (
        .run  (state_q.run),
        .count(state_q.count),
        .cmp  (state_q.cmp),
        .match(match)
    );

    assign match_ext = NSEL'(match);
    assign ovf_ev    = state_q.run && (&state_q.count);
    assign events    = {ovf_ev, match, cap_fire};

    always_comb begin
        logic [NFLG-1:0] clr;
        logic [SELW-1:0] s;
        state_d = state_q;
        clr     = '0;

        if (state_q.run) state_d.count = state_q.count + 1'b1;

        for (int c = 0; c < NCAP; c++)
            if (cap_fire[c]) state_d.cap[c] = state_q.count;

        for (int k = 0; k < NTG; k++)
            if (match[k]) state_d.tog[k] = ~state_q.tog[k];

        for (int j = 0; j < NSR; j++) begin
            s = state_q.sel[j*SELW +: SELW];
            if (match_ext[s]) begin
                if (state_q.pset[j])      state_d.sr[j] = 1'b1;
                else if (state_q.pclr[j]) state_d.sr[j] = 1'b0;
                state_d.pset[j] = 1'b0;
                state_d.pclr[j] = 1'b0;
            end
        end

        if (wr_en) begin
            if (wr_addr == A_TIMER) state_d.count     = wr_data;
            if (wr_addr == A_CTRL)  state_d.run       = wr_data[0];
            if (wr_addr == A_EDGE)  state_d.edge_mode = wr_data[2*NCAP-1:0];
            if (wr_addr == A_SEL)   state_d.sel       = wr_data[NSR*SELW-1:0];
            if (wr_addr == A_IREN)  state_d.irqen     = wr_data[NFLG-1:0];
            if (wr_addr == A_FLAG)  clr               = wr_data[NFLG-1:0];
            if (wr_addr == A_PEND) begin
                state_d.pset = wr_data[NSR-1:0];
                state_d.pclr = wr_data[PEND_CLR_LSB +: NSR];
            end
            for (int k = 0; k < NCMP; k++)
                if (wr_addr == A_CMP0 + AW'(k)) state_d.cmp[k] = wr_data;
        end

        state_d.flags = (state_q.flags & ~clr) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_TIMER) rd_data = state_q.count;
        if (rd_addr == A_CTRL)  rd_data = TW'(state_q.run);
        if (rd_addr == A_EDGE)  rd_data = TW'(state_q.edge_mode);
        if (rd_addr == A_SEL)   rd_data = TW'(state_q.sel);
        if (rd_addr == A_FLAG)  rd_data = TW'(state_q.flags);
        if (rd_addr == A_IREN)  rd_data = TW'(state_q.irqen);
        if (rd_addr == A_PEND)
            rd_data = TW'(state_q.pset) | (TW'(state_q.pclr) << PEND_CLR_LSB);
        for (int k = 0; k < NCMP; k++)
            if (rd_addr == A_CMP0 + AW'(k)) rd_data = state_q.cmp[k];
        for (int c = 0; c < NCAP; c++)
            if (rd_addr == A_CAP0 + AW'(c)) rd_data = state_q.cap[c];
    end

    assign sr_out  = state_q.sr;
    assign tog_out = state_q.tog;
    assign irq     = |(state_q.flags & state_q.irqen);
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          load,
    input logic [TW-1:0] count,
    input logic          match0,
    input logic          fire0,
    input logic          tog0,
    input logic          ovf_flag,
    input logic          cap_flag0,
    input logic          cmp_flag0
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (count == TW'($past(count) + 1'b1))); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count)); // R1
    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (&count)) |=> ovf_flag); // R2
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fire0 |=> cap_flag0); // R4
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        match0 |=> cmp_flag0); // R5
    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        match0 |=> (tog0 != $past(tog0))); // R6
    AST_TOG_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !match0 |=> $stable(tog0)); // R6
endmodule

bind cc_timer cct_checker #(.TW(TW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q.run),
    .load     (wr_en && (wr_addr == cct_pkg::A_TIMER)),
    .count    (state_q.count),
    .match0   (match[0]),
    .fire0    (cap_fire[0]),
    .tog0     (tog_out[0]),
    .ovf_flag (state_q.flags[NCAP+NCMP]),
    .cap_flag0(state_q.flags[0]),
    .cmp_flag0(state_q.flags[NCAP])
);

// File: tb/test_cc_timer.sv
module test_cc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  cap_in = '0;
    logic [5:0]  sr_out;
    logic [1:0]  tog_out;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 register, 1 pins {tog,sr}, 2 irq
        logic [3:0]  addr;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    cc_timer i_cc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .sr_out(sr_out), .tog_out(tog_out), .irq(irq)
    );

    task automatic expect_item(input int kind, input logic [3:0] a,
                               input logic [15:0] e, input string r);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run_for(input int n);
        wr(4'd1, 16'd1);
        repeat (n) @(posedge clk);
        #1;
        wr(4'd1, 16'd0);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it = q.pop_front();
                rd_addr = it.addr;
                #1;
                case (it.kind)
                    0:       got = rd_data;
                    1:       got = {8'd0, tog_out, sr_out};
                    default: got = {15'd0, irq};
                endcase
                compared++;
                if (got !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                             it.req, it.kind, it.addr, got, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // driver
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R10 reset state
        expect_item(0, 4'd0, 16'h0000, "R10");
        expect_item(0, 4'd12, 16'h0000, "R10");
        expect_item(1, 4'd0, 16'h0000, "R10");
        expect_item(2, 4'd0, 16'h0000, "R10");
        drain();

        // R1 load while stopped, hold, then run 10 steps
        wr(4'd0, 16'd100);
        repeat (4) @(posedge clk);
        #1;
        expect_item(0, 4'd0, 16'd100, "R1 hold");
        drain();
        run_for(9);
        expect_item(0, 4'd0, 16'd110, "R1 count");
        drain();

        // R2 overflow
        wr(4'd0, 16'hFFFF);
        run_for(0);
        expect_item(0, 4'd0, 16'h0000, "R2 wrap");
        expect_item(0, 4'd12, 16'h0080, "R2 flag");
        drain();
        wr(4'd12, 16'h00FF);

        // R5 R6 R7 compare round A
        wr(4'd2, 16'd5);
        wr(4'd3, 16'd7);
        wr(4'd4, 16'h0300);
        wr(4'd10, 16'h0FE4);
        wr(4'd11, 16'h000F);
        wr(4'd0, 16'd0);
        run_for(9);
        expect_item(1, 4'd0, 16'h00C3, "R6 R7 round A pins");
        expect_item(0, 4'd11, 16'h000C, "R7 pending consumed");
        expect_item(0, 4'd12, 16'h0030, "R5 match flags");
        drain();

        // R8 clear, R7 pending clear
        wr(4'd12, 16'h0030);
        expect_item(0, 4'd12, 16'h0000, "R8 clear");
        drain();
        wr(4'd11, 16'h010C);
        wr(4'd0, 16'd0);
        run_for(9);
        expect_item(1, 4'd0, 16'h0002, "R6 R7 round B pins");
        expect_item(0, 4'd11, 16'h000C, "R7 clear consumed");
        expect_item(0, 4'd12, 16'h0030, "R5 flags again");
        drain();

        // R8 zero writes have no effect, partial clear
        wr(4'd12, 16'h0000);
        expect_item(0, 4'd12, 16'h0030, "R8 zero write");
        drain();
        wr(4'd12, 16'h0010);
        expect_item(0, 4'd12, 16'h0020, "R8 partial");
        drain();

        // R9 interrupt enable
        expect_item(2, 4'd0, 16'h0000, "R9 disabled");
        drain();
        wr(4'd13, 16'h0020);
        expect_item(2, 4'd0, 16'h0001, "R9 enabled");
        drain();
        wr(4'd13, 16'h0001);
        expect_item(2, 4'd0, 16'h0000, "R9 other source");
        drain();

        // R3 R4 edge modes, timer stopped
        wr(4'd12, 16'h00FF);
        wr(4'd9, 16'h0039);
        wr(4'd0, 16'h1234);
        cap_in = 4'b1111;
        repeat (5) @(posedge clk);
        #1;
        expect_item(0, 4'd12, 16'h0005, "R3 rising flags");
        expect_item(0, 4'd5, 16'h1234, "R4 cap0");
        expect_item(0, 4'd6, 16'h0000, "R3 cap1 ignores rise");
        expect_item(0, 4'd7, 16'h1234, "R3 cap2 both");
        expect_item(0, 4'd8, 16'h0000, "R3 cap3 off");
        drain();
        wr(4'd0, 16'h2000);
        cap_in = 4'b0000;
        repeat (5) @(posedge clk);
        #1;
        expect_item(0, 4'd12, 16'h0007, "R3 falling flags");
        expect_item(0, 4'd5, 16'h1234, "R3 cap0 ignores fall");
        expect_item(0, 4'd6, 16'h2000, "R4 cap1");
        expect_item(0, 4'd7, 16'h2000, "R3 cap2 fall");
        expect_item(0, 4'd8, 16'h0000, "R3 cap3 still off");
        drain();

        // R4 latency while running
        wr(4'd0, 16'h0100);
        wr(4'd1, 16'd1);
        cap_in[0] = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        wr(4'd1, 16'd0);
        expect_item(0, 4'd5, 16'h0102, "R4 latency");
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule